// File: doc/BRIEF.md
# Reloading Down Counter with Terminal Count

The block is a small down counter of programmable width (seven bits by default). A period register holds the reload value. Whenever the count reaches zero while the counter is running, it reloads the period value on the next clock. To get a cycle of N clocks, the period register is loaded with N-1. A period of zero is not a working divider: the count then stays at zero and terminal count stays high.

Counting needs a software start bit. An optional hardware enable input gates counting further, and it only has an effect while the start bit is set. An optional level-sensitive load input forces a reload on every clock for as long as it is held, and it wins over a reload at zero.

A mode input picks one of two behaviours:
- Default mode: terminal count is a registered copy of "count is zero", and load acts only while the hardware enable is high.
- Alternate mode: terminal count is taken combinationally from the count, and load is independent of the enable.

The bus reaches the block through simple write strobes. It can always write the period. It can write the count only while the counter is stopped. Both registers can be read. A separate wake-clear input models loss of state in sleep: it clears the count but keeps the period.

Top module: `reload_downcounter`

## Requirements
- R1: While rstN is low, and on the first clock edge after it goes high, the count is 0 and periodRd is 0. sigOut[W] reads 0 in default mode; in alternate mode it reads 1 because the count is 0.
- R2: When the counter is running with no load, a nonzero count decrements by one per clock. A count of zero loads the period value on the next clock, so period P gives a repeating cycle of P+1 clocks.
- R3: With the period at 0 and the counter running, the count stays at 0 and terminal count stays at 1 on every cycle.
- R4: The counter runs only when startBit is 1 and the effective enable is 1. With USE_ENABLE=1 the effective enable is hwEnable; with USE_ENABLE=0 it is always 1. When the counter is not running, the count holds.
- R5: Load is level sensitive. On every clock edge where the effective load is 1, the count takes the period value, whether or not it is zero and whether or not the counter is running. With USE_LOAD=0 the effective load is always 0.
- R6: With altMode=0, the effective load is hwLoad AND the effective enable. With altMode=1, the effective load is hwLoad alone. Neither case depends on startBit.
- R7: With altMode=1, sigOut[W] is 1 exactly when the current count is 0. With altMode=0, sigOut[W] shows whether the count was 0 before the last clock edge, so it lags one clock.
- R8: A pulse on wrCount loads wrData into the count only on an edge where the counter is stopped, there is no effective load and there is no wake-clear. Otherwise the write is ignored.
- R9: A pulse on wrPeriod loads wrData into the period register in any state. A pulse on wakeClr sets the count to 0 on the next clock and has priority over load, reload, decrement and count writes. wakeClr leaves the period unchanged.
- R10: sigOut[W-1:0] carries the count and sigOut[W] carries terminal count. periodRd carries the period register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Asynchronous active-low reset of all state |
| altMode | input | 1 | 0 = registered terminal count, load needs enable; 1 = combinational terminal count, independent load |
| startBit | input | 1 | Software start bit |
| hwEnable | input | 1 | Hardware enable (used when USE_ENABLE=1) |
| hwLoad | input | 1 | Level-sensitive hardware load (used when USE_LOAD=1) |
| wakeClr | input | 1 | Clears the count, keeps the period |
| wrCount | input | 1 | Count write strobe |
| wrPeriod | input | 1 | Period write strobe |
| wrData | input | W | Write data for count or period |
| sigOut | output | W+1 | {terminal count, count} |
| periodRd | output | W | Period register read value |

## Verification
The hardest case to reach is a held load that overlaps the clock on which the count hits zero. The same case also needs to meet the one-clock lag of registered terminal count, and it must be tried with the enable both high and low in each mode. The stimulus gets there in steps. It first sets a short period so that zeros come often. It then holds load across several clocks, including a zero, with the enable on and then off, once in each mode. A long randomized phase follows, in which writes to the count and period, wake-clears and mode changes land at arbitrary counts. A second instance has both optional inputs disabled and shows that hwEnable and hwLoad are ignored there.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  // One-hot set of actions the control logic requests from the datapath
  typedef struct packed {
    logic clear;   // wake-clear of the count
    logic load;    // level load of the period
    logic reload;  // reload at zero while running
    logic dec;     // decrement while running
    logic write;   // bus write of the count while stopped
  } cntStrobe_t;
endpackage

// File: rtl/rdc_ctrl.sv
module rdc_ctrl
  import rdc_pkg::*;
#(
  parameter bit USE_LOAD   = 1'b1,
  parameter bit USE_ENABLE = 1'b1
) (
  input  logic       altMode,
  input  logic       startBit,
  input  logic       hwEnable,
  input  logic       hwLoad,
  input  logic       wakeClr,
  input  logic       wrCount,
  input  logic       countIsZero,
  output cntStrobe_t strobe
);
  logic enIn;
  logic ldIn;
  logic running;
  logic ldEff;

  generate
    if (USE_ENABLE) begin : g_en
      assign enIn = hwEnable;
    end else begin : g_noen
      assign enIn = 1'b1;
    end
    if (USE_LOAD) begin : g_ld
      assign ldIn = hwLoad;
    end else begin : g_nold
      assign ldIn = 1'b0;
    end
  endgenerate

  assign running = startBit & enIn;
  assign ldEff   = ldIn & (altMode | enIn);

  always_comb begin
    strobe        = '0;
    strobe.clear  = wakeClr;
    strobe.load   = !wakeClr && ldEff;
    strobe.reload = !wakeClr && !ldEff && running && countIsZero;
    strobe.dec    = !wakeClr && !ldEff && running && !countIsZero;
    strobe.write  = !wakeClr && !ldEff && !running && wrCount;
  end
endmodule

// File: rtl/rdc_datapath.sv
module rdc_datapath
  import rdc_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  cntStrobe_t   strobe,
  input  logic         wrPeriod,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] count,
  output logic [W-1:0] period,
  output logic         countIsZero,
  output logic         tcReg
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assign countIsZero = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      period <= '0;
      tcReg  <= 1'b0;
    end else begin
      tcReg <= countIsZero;
      if (wrPeriod) period <= wrData;
      if (strobe.clear)                     count <= '0;
      else if (strobe.load || strobe.reload) count <= period;
      else if (strobe.dec)                   count <= count - ONE;
      else if (strobe.write)                 count <= wrData;
    end
  end
endmodule

// File: rtl/reload_downcounter.sv
module reload_downcounter
  import rdc_pkg::*;
#(
  parameter int W          = 7,
  parameter bit USE_LOAD   = 1'b1,
  parameter bit USE_ENABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         altMode,
  input  logic         startBit,
  input  logic         hwEnable,
  input  logic         hwLoad,
  input  logic         wakeClr,
  input  logic         wrCount,
  input  logic         wrPeriod,
  input  logic [W-1:0] wrData,
  output logic [W:0]   sigOut,
  output logic [W-1:0] periodRd
);
  cntStrobe_t   strobe;
  logic         countIsZero;
  logic         tcReg;
  logic [W-1:0] count;

  rdc_ctrl #(.USE_LOAD(USE_LOAD), .USE_ENABLE(USE_ENABLE)) u_ctrl (
    .altMode(altMode), .startBit(startBit), .hwEnable(hwEnable),
    .hwLoad(hwLoad), .wakeClr(wakeClr), .wrCount(wrCount),
    .countIsZero(countIsZero), .strobe(strobe)
  );

  rdc_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPeriod(wrPeriod),
    .wrData(wrData), .count(count), .period(periodRd),
    .countIsZero(countIsZero), .tcReg(tcReg)
  );

  assign sigOut = {(altMode ? countIsZero : tcReg), count};
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
  parameter int W          = 7,
  parameter bit USE_LOAD   = 1'b1,
  parameter bit USE_ENABLE = 1'b1
) (
  input logic         clk,
  input logic         rstN,
  input logic         altMode,
  input logic         startBit,
  input logic         hwEnable,
  input logic         hwLoad,
  input logic         wakeClr,
  input logic         wrCount,
  input logic         wrPeriod,
  input logic [W-1:0] wrData,
  input logic [W:0]   sigOut,
  input logic [W-1:0] periodRd
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] cnt;
  logic tc, enC, ldC, runC, pastOk;

  assign cnt  = sigOut[W-1:0];
  assign tc   = sigOut[W];
  assign enC  = USE_ENABLE ? hwEnable : 1'b1;
  assign ldC  = USE_LOAD ? (hwLoad & (altMode | enC)) : 1'b0;
  assign runC = startBit & enC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R9
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeClr && !wrPeriod |=> cnt == '0 && $stable(periodRd));

  // R9
  period_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPeriod |=> periodRd == $past(wrData));

  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runC && !ldC && !wakeClr && !wrCount |=> $stable(cnt));

  // R2
  decrement_chk: assert property (@(posedge clk) disable iff (!rstN)
    runC && !ldC && !wakeClr && cnt != '0 |=> cnt == $past(cnt) - ONE);

  // R5
  level_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldC && !wakeClr |=> cnt == $past(periodRd));

  // R7
  registered_tc_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !altMode |-> tc == ($past(cnt) == '0));
endmodule

bind reload_downcounter rdc_checker #(.W(W), .USE_LOAD(USE_LOAD), .USE_ENABLE(USE_ENABLE))
  u_chk (.*);

// File: tb/tb_reload_downcounter.sv
module tb_reload_downcounter;
  localparam int W = 7;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic altMode = 0, startBit = 0, hwEnable = 0, hwLoad = 0;
  logic wakeClr = 0, wrCount = 0, wrPeriod = 0;
  logic [W-1:0] wrData = '0;
  logic [W:0]   sigOut, sigOut2;
  logic [W-1:0] periodRd, periodRd2;

  int checks = 0, errors = 0, cycles = 0;
  string curReq = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  reload_downcounter #(.W(W), .USE_LOAD(1'b1), .USE_ENABLE(1'b1)) dut (
    .clk(clk), .rstN(rstN), .altMode(altMode), .startBit(startBit),
    .hwEnable(hwEnable), .hwLoad(hwLoad), .wakeClr(wakeClr), .wrCount(wrCount),
    .wrPeriod(wrPeriod), .wrData(wrData), .sigOut(sigOut), .periodRd(periodRd));

  reload_downcounter #(.W(W), .USE_LOAD(1'b0), .USE_ENABLE(1'b0)) dutNoHw (
    .clk(clk), .rstN(rstN), .altMode(altMode), .startBit(startBit),
    .hwEnable(hwEnable), .hwLoad(hwLoad), .wakeClr(wakeClr), .wrCount(wrCount),
    .wrPeriod(wrPeriod), .wrData(wrData), .sigOut(sigOut2), .periodRd(periodRd2));

  // Reference model state
  int c1 = 0, p1 = 0, t1 = 0, c2 = 0, p2 = 0, t2 = 0;

  function automatic int nextCount(int c, int p, bit en, bit ld, bit clr, bit wr, int d);
    if (clr) return 0;
    if (ld) return p;
    if (en) return (c == 0) ? p : c - 1;
    if (wr) return d;
    return c;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      c1 = 0; p1 = 0; t1 = 0; c2 = 0; p2 = 0; t2 = 0;
    end else begin
      t1 = (c1 == 0); t2 = (c2 == 0);
      c1 = nextCount(c1, p1, startBit && hwEnable, hwLoad && (altMode || hwEnable),
                     wakeClr, wrCount, int'(wrData));
      c2 = nextCount(c2, p2, startBit, 1'b0, wakeClr, wrCount, int'(wrData));
      if (wrPeriod) begin p1 = int'(wrData); p2 = int'(wrData); end
    end
    #2;
    if (!done) begin
      check(curReq, "count (R10)", int'(sigOut[W-1:0]), c1);
      check(curReq, "tc (R7)", int'(sigOut[W]), altMode ? int'(c1 == 0) : t1);
      check(curReq, "period (R9)", int'(periodRd), p1);
      check(curReq, "noHw count (R4)", int'(sigOut2[W-1:0]), c2);
      check(curReq, "noHw tc (R5)", int'(sigOut2[W]), altMode ? int'(c2 == 0) : t2);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(bit toPeriod, int val);
    wrData = W'(val);
    if (toPeriod) wrPeriod = 1; else wrCount = 1;
    tick(1);
    wrPeriod = 0; wrCount = 0;
  endtask

  task automatic finish();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    finish();
  end

  initial begin
    tick(3);
    curReq = "R1";
    check("R1", "reset count", int'(sigOut[W-1:0]), 0);
    check("R1", "reset tc", int'(sigOut[W]), 0);
    rstN = 1;
    tick(2);
    // Period 4 gives a five-clock cycle
    curReq = "R8";
    busWrite(1, 4);
    busWrite(0, 2);
    check("R8", "stopped write", int'(sigOut[W-1:0]), 2);
    curReq = "R2";
    startBit = 1; hwEnable = 1;
    tick(12);
    curReq = "R8";
    busWrite(0, 9);
    curReq = "R7";
    altMode = 1;
    tick(8);
    curReq = "R4";
    hwEnable = 0; tick(4);
    startBit = 0; hwEnable = 1; tick(4);
    startBit = 1;
    curReq = "R5";
    tick(2);
    hwLoad = 1; tick(4); hwLoad = 0;
    tick(3);
    curReq = "R6";
    altMode = 0; hwEnable = 0; hwLoad = 1; tick(3);
    altMode = 1; tick(3);
    hwLoad = 0; hwEnable = 1; altMode = 0; tick(2);
    curReq = "R3";
    busWrite(1, 0);
    tick(10);
    altMode = 1; tick(4);
    curReq = "R9";
    busWrite(1, 6);
    tick(3);
    wakeClr = 1; tick(1); wakeClr = 0;
    check("R9", "period kept", int'(periodRd), 6);
    tick(4);
    curReq = "R2";
    for (int i = 0; i < 400; i++) begin
      altMode  = ($urandom % 8) == 0 ? ~altMode : altMode;
      startBit = ($urandom % 8) != 0;
      hwEnable = ($urandom % 6) != 0;
      hwLoad   = ($urandom % 10) == 0;
      wakeClr  = ($urandom % 40) == 0;
      wrCount  = ($urandom % 5) == 0;
      wrPeriod = ($urandom % 25) == 0;
      wrData   = W'($urandom % 12);
      tick(1);
    end
    wakeClr = 0; wrCount = 0; wrPeriod = 0; hwLoad = 0;
    tick(2);
    finish();
  end
endmodule